// File: doc/BRIEF.md
# Linked-Load / Conditional-Store Reservation Unit

This block keeps the single reservation that pairs a linked word load with a later conditional word store. A linked load reads one 32-bit word from memory. It hands that word back for the destination register and records both the effective address and the word it read. A conditional store succeeds only when two things hold. Its address must equal the recorded address, and memory must still hold the recorded word when the store is attempted. The compare read and the write run under a held memory lock, so no other requester can slip in between them. The success flag is then presented for the status flag bit.

The pipeline issues an operation with a one-cycle strobe, a kind bit, the effective address and the store data (the word from the source register). The unit accepts an operation only in its idle state and signals completion with a one-cycle `done` pulse. The states are IDLE, LL_READ, SC_READ, SC_WRITE and FINISH. Transitions:
- IDLE→LL_READ on a linked load.
- IDLE→SC_READ on a conditional store whose address hits.
- IDLE→FINISH on a conditional store whose address misses.
- LL_READ→FINISH on acknowledge.
- SC_READ→SC_WRITE on acknowledge with a matching word.
- SC_READ→FINISH on acknowledge with a differing word.
- SC_WRITE→FINISH on acknowledge.
- FINISH→IDLE always.

Top module: `llsc_unit`

## Requirements
- R1: After reset the reservation address is all ones, no memory request is raised, `done` and `flag_we` are low, and a conditional store issued before any linked load fails without writing memory.
- R2: A linked load (`op_kind`=0) reads the word at `op_addr` and, with `done`, asserts `load_we` and returns that word on `load_data`.
- R3: A linked load records its address and the loaded word, replacing any earlier reservation; a conditional store to an older reserved address then fails.
- R4: A conditional store (`op_kind`=1) whose address differs from the reserved address makes no memory request, completes one cycle after the strobe, and reports flag 0.
- R5: A conditional store whose address matches and whose locked read returns the reserved word writes `op_wdata` to that address and reports flag 1.
- R6: A conditional store whose address matches but whose locked read returns a different word performs no write and reports flag 0.
- R7: After every conditional store, pass or fail, the reservation address returns to all ones, so a repeated conditional store fails.
- R8: Every request of a conditional store carries `mem_lock` high, from the compare read through the write; linked-load requests carry it low, and no write is issued without the lock.
- R9: `done` is a single-cycle pulse per operation; `flag_we` rises with it only for conditional stores, `load_we` only for linked loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | One-cycle operation strobe, taken in IDLE |
| op_kind | input | 1 | 0 linked load, 1 conditional store |
| op_addr | input | 32 | Effective address |
| op_wdata | input | 32 | Store data for a conditional store |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_lock | output | 1 | Hold the memory against other requesters |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with acknowledge |
| mem_ack | input | 1 | Memory acknowledge for the current request |
| load_we | output | 1 | Destination register write, with `done` |
| load_data | output | 32 | Word returned by a linked load |
| flag_we | output | 1 | Status flag update, with `done` |
| flag_val | output | 1 | Conditional store outcome |
| done | output | 1 | Operation complete pulse |

## Verification
A reservation address that is not cleared shows up at the next repeated conditional store. That store makes a locked request instead of finishing one cycle after its strobe, and its flag reads 1. A reservation value that is captured wrongly shows as a failed store against unchanged memory, or a passing one against changed memory. Either case is visible at the `done` of that same store. A lock dropped between read and write appears on the very request cycle as `mem_lock` low with `mem_req` high. A leaked write appears in the word read back by the next linked load to that address.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_LL_READ = 3'd1,
        ST_SC_READ = 3'd2,
        ST_SC_WRITE = 3'd3,
        ST_FINISH  = 3'd4
    } llsc_state_e;

    typedef enum logic {
        KIND_LINKED_LOAD = 1'b0,
        KIND_COND_STORE  = 1'b1
    } llsc_kind_e;

endpackage

// File: rtl/llsc_resv.sv
module llsc_resv #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [AW-1:0] set_addr,
    input  logic [DW-1:0] set_val,
    input  logic          clr_en,
    input  logic [AW-1:0] chk_addr,
    input  logic [DW-1:0] chk_data,
    output logic          addr_hit,
    output logic          data_match,
    output logic [AW-1:0] rsv_addr
);

    localparam logic [AW-1:0] NO_RESV = {AW{1'b1}};

    logic [DW-1:0] rsv_val;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsv_addr <= NO_RESV;
            rsv_val  <= '0;
        end else if (set_en) begin
            rsv_addr <= set_addr;
            rsv_val  <= set_val;
        end else if (clr_en) begin
            rsv_addr <= NO_RESV;
        end
    end

    assign addr_hit   = (chk_addr == rsv_addr);
    assign data_match = (chk_data == rsv_val);

endmodule

// File: rtl/llsc_ctrl.sv
module llsc_ctrl
    import llsc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic op_valid,
    input  logic op_is_sc,
    input  logic addr_hit,
    input  logic data_match,
    input  logic mem_ack,
    output logic mem_req,
    output logic mem_we,
    output logic mem_lock,
    output logic latch_op,
    output logic ll_capture,
    output logic sc_pass,
    output logic sc_fail,
    output logic clear_rsv,
    output logic done
);

    llsc_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        latch_op   = 1'b0;
        ll_capture = 1'b0;
        sc_pass    = 1'b0;
        sc_fail    = 1'b0;
        clear_rsv  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (op_valid) begin
                    latch_op = 1'b1;
                    if (!op_is_sc) begin
                        state_d = ST_LL_READ;
                    end else if (addr_hit) begin
                        state_d = ST_SC_READ;
                    end else begin
                        sc_fail   = 1'b1;
                        clear_rsv = 1'b1;
                        state_d   = ST_FINISH;
                    end
                end
            end
            ST_LL_READ: begin
                if (mem_ack) begin
                    ll_capture = 1'b1;
                    state_d    = ST_FINISH;
                end
            end
            ST_SC_READ: begin
                if (mem_ack) begin
                    if (data_match) begin
                        state_d = ST_SC_WRITE;
                    end else begin
                        sc_fail   = 1'b1;
                        clear_rsv = 1'b1;
                        state_d   = ST_FINISH;
                    end
                end
            end
            ST_SC_WRITE: begin
                if (mem_ack) begin
                    sc_pass   = 1'b1;
                    clear_rsv = 1'b1;
                    state_d   = ST_FINISH;
                end
            end
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req  = 1'b0;
        mem_we   = 1'b0;
        mem_lock = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE:     ;
            ST_LL_READ:  mem_req = 1'b1;
            ST_SC_READ: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
            end
            ST_SC_WRITE: begin
                mem_req  = 1'b1;
                mem_lock = 1'b1;
                mem_we   = 1'b1;
            end
            ST_FINISH:   done = 1'b1;
            default:     ;
        endcase
    end

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_miss_no_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && op_valid && op_is_sc && !addr_hit) |=> (done && !mem_req));

    assert_lock_through_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_lock && !mem_we && mem_ack && data_match) |=> (mem_req && mem_we && mem_lock));

endmodule

// File: rtl/llsc_unit.sv
module llsc_unit
    import llsc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_kind,
    input  logic [AW-1:0] op_addr,
    input  logic [DW-1:0] op_wdata,
    output logic          mem_req,
    output logic          mem_we,
    output logic          mem_lock,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    input  logic [DW-1:0] mem_rdata,
    input  logic          mem_ack,
    output logic          load_we,
    output logic [DW-1:0] load_data,
    output logic          flag_we,
    output logic          flag_val,
    output logic          done
);

    logic          op_is_sc;
    logic          addr_hit, data_match;
    logic [AW-1:0] rsv_addr;
    logic          latch_op, ll_capture, sc_pass, sc_fail, clear_rsv;
    logic          kind_sc_q;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q;
    logic [DW-1:0] load_q;
    logic          flag_q;

    assign op_is_sc = (llsc_kind_e'(op_kind) == KIND_COND_STORE);

    llsc_resv #(.AW(AW), .DW(DW)) u_resv (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_en     (ll_capture),
        .set_addr   (addr_q),
        .set_val    (mem_rdata),
        .clr_en     (clear_rsv),
        .chk_addr   (op_addr),
        .chk_data   (mem_rdata),
        .addr_hit   (addr_hit),
        .data_match (data_match),
        .rsv_addr   (rsv_addr)
    );

    llsc_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_is_sc   (op_is_sc),
        .addr_hit   (addr_hit),
        .data_match (data_match),
        .mem_ack    (mem_ack),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_lock   (mem_lock),
        .latch_op   (latch_op),
        .ll_capture (ll_capture),
        .sc_pass    (sc_pass),
        .sc_fail    (sc_fail),
        .clear_rsv  (clear_rsv),
        .done       (done)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_sc_q <= 1'b0;
            addr_q    <= '0;
            wdata_q   <= '0;
            load_q    <= '0;
            flag_q    <= 1'b0;
        end else begin
            if (latch_op) begin
                kind_sc_q <= op_is_sc;
                addr_q    <= op_addr;
                wdata_q   <= op_wdata;
            end
            if (ll_capture) load_q <= mem_rdata;
            if (sc_pass)      flag_q <= 1'b1;
            else if (sc_fail) flag_q <= 1'b0;
        end
    end

    assign mem_addr  = addr_q;
    assign mem_wdata = wdata_q;
    assign load_data = load_q;
    assign load_we   = done && !kind_sc_q;
    assign flag_we   = done && kind_sc_q;
    assign flag_val  = flag_q;

    assert_write_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> mem_lock);

    assert_resv_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_we |-> (rsv_addr == {AW{1'b1}}));

    assert_pass_follows_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_we && flag_val) |-> $past(mem_req && mem_we && mem_ack));

endmodule

// File: tb/llsc_unit_tb.sv
module llsc_unit_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NWORDS = 16;

    typedef struct packed {
        logic        kind;
        logic        poke;
        logic [3:0]  pidx;
        logic [31:0] pval;
        logic [31:0] addr;
        logic [31:0] data;
        logic        eflag;
        logic [31:0] erd;
        logic        ewr;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h08, 32'h0000DEAD, 1'b0, 32'h0,        1'b0}, // R1
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h08, 32'h0,        1'b0, 32'h00001002, 1'b0}, // R2
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h08, 32'hAAAA0001, 1'b1, 32'h0,        1'b1}, // R5
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h08, 32'h00000005, 1'b0, 32'h0,        1'b0}, // R7
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h08, 32'h0,        1'b0, 32'hAAAA0001, 1'b0}, // R5
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h10, 32'h0,        1'b0, 32'h00001004, 1'b0}, // R2
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h14, 32'h00000007, 1'b0, 32'h0,        1'b0}, // R4
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h10, 32'h00000009, 1'b0, 32'h0,        1'b0}, // R7
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h10, 32'h0,        1'b0, 32'h00001004, 1'b0}, // R3
        '{1'b1, 1'b1, 4'd4, 32'h77,   32'h10, 32'h00000009, 1'b0, 32'h0,        1'b0}, // R6
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h10, 32'h0,        1'b0, 32'h00000077, 1'b0}, // R6
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h18, 32'h0,        1'b0, 32'h00001006, 1'b0}, // R2
        '{1'b1, 1'b1, 4'd6, 32'h1006, 32'h18, 32'h00000001, 1'b1, 32'h0,        1'b1}, // R5
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h0C, 32'h0,        1'b0, 32'h00001003, 1'b0}, // R3
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h20, 32'h0,        1'b0, 32'h00001008, 1'b0}, // R3
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h0C, 32'h00000002, 1'b0, 32'h0,        1'b0}, // R3
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h1C, 32'h0,        1'b0, 32'h00001007, 1'b0}, // R2
        '{1'b1, 1'b0, 4'd0, 32'h0,    32'h1C, 32'h00000033, 1'b1, 32'h0,        1'b1}, // R5
        '{1'b0, 1'b0, 4'd0, 32'h0,    32'h1C, 32'h0,        1'b0, 32'h00000033, 1'b0}  // R5
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic        op_kind = 1'b0;
    logic [31:0] op_addr = '0;
    logic [31:0] op_wdata = '0;
    logic        mem_req, mem_we, mem_lock;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_ack;
    logic        load_we, flag_we, flag_val, done;
    logic [31:0] load_data;

    int checks = 0;
    int fails = 0;
    int wr_count = 0;
    int lock_err = 0;
    int dbl_done = 0;
    logic cur_sc = 1'b0;
    logic done_prev = 1'b0;
    logic poke_en = 1'b0;
    logic [3:0]  poke_idx = '0;
    logic [31:0] poke_val = '0;
    logic [31:0] mem [NWORDS];

    always #(CLK_PERIOD/2) clk = ~clk;

    llsc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind),
        .op_addr(op_addr), .op_wdata(op_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_lock(mem_lock), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .load_we(load_we),
        .load_data(load_data), .flag_we(flag_we), .flag_val(flag_val), .done(done)
    );

    // Memory model: acknowledge one cycle after a request, plus a side port for another requester
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            if (wr_count == 0 && lock_err == 0)
                for (int i = 0; i < NWORDS; i++) mem[i] <= 32'h1000 + i;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[5:2]];
                if (mem_we) begin
                    mem[mem_addr[5:2]] <= mem_wdata;
                    wr_count <= wr_count + 1;
                end
            end
            if (poke_en) mem[poke_idx] <= poke_val;
        end
    end

    // Protocol monitors
    always @(posedge clk) begin
        if (rst_n) begin
            if (mem_req && mem_we && !mem_lock) lock_err <= lock_err + 1;
            if (mem_req && cur_sc && !mem_lock) lock_err <= lock_err + 1;
            if (mem_req && !cur_sc && mem_lock) lock_err <= lock_err + 1;
            if (done && done_prev) dbl_done <= dbl_done + 1;
            done_prev <= done;
        end else begin
            done_prev <= 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic poke(input logic [3:0] idx, input logic [31:0] val);
        poke_en = 1'b1; poke_idx = idx; poke_val = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic run_op(input logic kind, input logic [31:0] addr, input logic [31:0] data,
                          input string req, output logic got_flag, output logic got_fwe,
                          output logic got_lwe, output logic [31:0] got_rd,
                          output int wr_delta, output int lat);
        int w0;
        w0 = wr_count;
        cur_sc = kind;
        op_kind = kind; op_addr = addr; op_wdata = data; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
        lat = 1;
        for (int i = 0; i < 40 && !done; i++) begin
            @(negedge clk);
            lat++;
        end
        check(done === 1'b1, req, "done seen", {31'b0, done}, 32'h1);
        got_flag = flag_val; got_fwe = flag_we; got_lwe = load_we; got_rd = load_data;
        @(negedge clk);
        wr_delta = wr_count - w0;
        check(done === 1'b0, "R9", "done one cycle", {31'b0, done}, 32'h0);
        cur_sc = 1'b0;
    endtask

    bit finished = 1'b0;

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic f, fwe, lwe;
        logic [31:0] rd;
        int wd, lat;
        do_reset();
        // R1 reset state
        check(done === 1'b0 && mem_req === 1'b0 && flag_we === 1'b0, "R1", "reset outputs",
              {29'b0, done, mem_req, flag_we}, 32'h0);

        for (int v = 0; v < NV; v++) begin
            if (VECS[v].poke) poke(VECS[v].pidx, VECS[v].pval);
            run_op(VECS[v].kind, VECS[v].addr, VECS[v].data, "vec", f, fwe, lwe, rd, wd, lat);
            if (VECS[v].kind) begin
                check(fwe === 1'b1 && lwe === 1'b0, "R9", "store strobes", {30'b0, fwe, lwe}, 32'h2);
                check(f === VECS[v].eflag, "R5/R6 (R4 R7 R3 R1)", "store flag", {31'b0, f}, {31'b0, VECS[v].eflag});
                check(wd == int'(VECS[v].ewr), "R6", "write count", wd, {31'b0, VECS[v].ewr});
            end else begin
                check(lwe === 1'b1 && fwe === 1'b0, "R9", "load strobes", {30'b0, fwe, lwe}, 32'h1);
                check(rd === VECS[v].erd, "R2", "load data", rd, VECS[v].erd);
            end
        end

        // R4 address miss completes one cycle after the strobe
        run_op(1'b0, 32'h24, 32'h0, "R4", f, fwe, lwe, rd, wd, lat);
        run_op(1'b1, 32'h28, 32'h5, "R4", f, fwe, lwe, rd, wd, lat);
        check(lat == 1, "R4", "miss latency", lat, 32'd1);
        check(f === 1'b0 && wd == 0, "R4", "miss outcome", {31'b0, f}, 32'h0);

        // R1 reset in the middle drops the reservation
        run_op(1'b0, 32'h04, 32'h0, "R1", f, fwe, lwe, rd, wd, lat);
        do_reset();
        run_op(1'b1, 32'h04, 32'h99, "R1", f, fwe, lwe, rd, wd, lat);
        check(f === 1'b0 && wd == 0, "R1", "store after reset", {31'b0, f}, 32'h0);

        // R8 lock discipline, R9 pulse width across the run
        check(lock_err == 0, "R8", "lock violations", lock_err, 32'h0);
        check(dbl_done == 0, "R9", "stretched done", dbl_done, 32'h0);
        finish_run();
    end

endmodule